// File: doc/BRIEF.md
# Rotating Thermometer Selector for a Segmented Capacitor DAC

This block is the digital control side of a 12-bit segmented switched-capacitor converter. Each accepted input word is split into two halves. The lower six bits drive a binary-weighted capacitor group unchanged. The upper six bits, a value m from 0 to 63, pick m cells out of 63 equal unit capacitors.

When matching is switched on, the m chosen cells form a run. The run starts at a rotating start index and wraps at 63. The index then moves past the run, so every cell is used in turn at the fastest possible rate. This turns static cell mismatch into noise at high frequency, which averages out. When matching is switched off, the run always starts at cell 0.

For every conversion the block also sequences the capacitor switches in two non-overlapping steps. In the first step the cells are charged to a reference. In the second step they share charge with the feedback capacitor. A per-conversion flag decides whether the feedback capacitor is cleared during the first step. An idle input stops all switching.

Top module: `dwa_dac_ctrl`

## Requirements
- R1: From the clock edge that accepts a code, `lsb_sw_o` equals bits [5:0] of that code. It holds that value until the next accepted code.
- R2: From the accepting edge, `unit_sel_o` has exactly m bits set, where m is bits [11:6] of the code. m = 0 sets no bit and m = 63 sets all 63 bits.
- R3: With `dem_en_i` low at acceptance, `unit_sel_o` sets bits 0 to m−1. The start index is left unchanged.
- R4: With `dem_en_i` high at acceptance, `unit_sel_o` sets bits p, p+1, …, p+m−1, each taken modulo 63, where p is the start index. The start index then becomes (p+m) mod 63. m = 0 leaves it unchanged.
- R5: Across any run of matching-enabled conversions after reset, the number of times any two cells have been selected differs by at most one.
- R6: After acceptance, the switch controls follow a fixed order:
  - `ph1_o` is high for 2 cycles;
  - then both controls are low for 1 cycle;
  - then `ph2_o` is high for 2 cycles;
  - then both are low for 1 cycle.
  `ph1_o` and `ph2_o` are never high together.
- R7: `fb_rst_o` is high exactly in the `ph1_o` cycles of a conversion whose `rst_en_i` was high at acceptance. Otherwise it is low.
- R8: `code_valid_i` is acted on only when no conversion is in progress. A strobe that arrives during a conversion changes no output and does not move the start index.
- R9: While `idle_i` is high, no code is accepted. `ph1_o`, `ph2_o` and `unit_sel_o` stay constant.
- R10: A synchronous reset does the following:
  - clears the start index to 0;
  - drives `ph1_o`, `ph2_o` and `fb_rst_o` low;
  - clears `unit_sel_o` and `lsb_sw_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| idle_i | input | 1 | Stop accepting codes and switching |
| dem_en_i | input | 1 | 1 = rotate the selection, 0 = fixed selection from cell 0 |
| rst_en_i | input | 1 | 1 = clear the feedback capacitor during this conversion's first step |
| code_valid_i | input | 1 | Strobe for `code_i` |
| code_i | input | 12 | Input code: [11:6] unit count m, [5:0] binary part |
| lsb_sw_o | output | 6 | Binary capacitor controls |
| unit_sel_o | output | 63 | Unit cell selection, bit i = cell i connected to the positive reference |
| ph1_o | output | 1 | Charge-step switch enable |
| ph2_o | output | 1 | Charge-sharing-step switch enable |
| fb_rst_o | output | 1 | Feedback capacitor clear |

## Verification
The assertions check the following on every clock cycle:
- the selection has as many bits set as the stored unit count;
- a run starts at the previous start index, or at cell 0 in fixed mode;
- the start index stays below 63 and moves whenever the count is neither 0 nor 63;
- the two switch steps never overlap, and the step-2 control never rises straight after step 1;
- the clear signal appears only inside step 1;
- nothing changes while idle;
- reset takes effect on the next edge.

Some behaviour only the bench can show. Exact selected positions over wrap-around, including m = 0 and m = 63, come from a reference model of the start index. So do the exact step lengths and the balance of per-cell usage over hundreds of random codes. The bench also shows that strobes during a conversion or in idle are dropped, and that fixed mode keeps the start index intact.

// File: rtl/dwa_pkg.sv
package dwa_pkg;

  localparam int DWA_LSB_W = 6;
  localparam int DWA_MSB_W = 6;

  typedef enum logic [2:0] {
    SEQ_WAIT = 3'd0,
    SEQ_PH1  = 3'd1,
    SEQ_GAP1 = 3'd2,
    SEQ_PH2  = 3'd3,
    SEQ_GAP2 = 3'd4
  } seq_state_e;

endpackage

// File: rtl/dwa_pointer.sv
module dwa_pointer #(
  parameter int MSB_W = dwa_pkg::DWA_MSB_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv_i,
  input  logic [MSB_W-1:0] step_i,
  output logic [MSB_W-1:0] ptr_o
);

  localparam int N_UNIT = (1 << MSB_W) - 1;

  // (p + s) mod N_UNIT for p < N_UNIT and s <= N_UNIT
  function automatic logic [MSB_W-1:0] wrap_add(input logic [MSB_W-1:0] p,
                                               input logic [MSB_W-1:0] s);
    logic [MSB_W:0] sum;
    sum = {1'b0, p} + {1'b0, s};
    if (sum >= (MSB_W+1)'(N_UNIT)) sum = sum - (MSB_W+1)'(N_UNIT);
    return sum[MSB_W-1:0];
  endfunction

  logic [MSB_W-1:0] ptr_q;
  logic [MSB_W-1:0] ptr_nxt;

  assign ptr_nxt = wrap_add(ptr_q, step_i);

  always_ff @(posedge clk) begin
    if (rst)        ptr_q <= '0;
    else if (adv_i) ptr_q <= ptr_nxt;
  end

  assign ptr_o = ptr_q;

  // R4: the index never reaches the all-ones value
  assert_ptr_range_R4: assert property (@(posedge clk) disable iff (rst)
    ptr_q < MSB_W'(N_UNIT));

  // R4: a partial step always moves the index
  assert_ptr_moves_R4: assert property (@(posedge clk) disable iff (rst)
    (adv_i && step_i != '0 && step_i != MSB_W'(N_UNIT)) |=> ptr_q != $past(ptr_q));

  // R4: a zero or full step leaves the index where it was
  assert_ptr_still_R4: assert property (@(posedge clk) disable iff (rst)
    (adv_i && (step_i == '0 || step_i == MSB_W'(N_UNIT))) |=> $stable(ptr_q));

  // R10: reset clears the index
  assert_ptr_reset_R10: assert property (@(posedge clk)
    rst |=> ptr_q == '0);

endmodule

// File: rtl/dwa_unit_select.sv
module dwa_unit_select #(
  parameter int MSB_W = dwa_pkg::DWA_MSB_W
) (
  input  logic [MSB_W-1:0]            count_i,
  input  logic [MSB_W-1:0]            start_i,
  input  logic                        rotate_i,
  output logic [(1 << MSB_W)-2:0]     sel_o
);

  localparam int N_UNIT = (1 << MSB_W) - 1;

  logic [N_UNIT-1:0] therm;
  logic [N_UNIT-1:0] rotated;

  // thermometer: cell i set when i < count
  for (genvar i = 0; i < N_UNIT; i++) begin : g_therm
    assign therm[i] = MSB_W'(i) < count_i;
  end

  // move bit i to position (i + p) mod N_UNIT
  function automatic logic [N_UNIT-1:0] spin(input logic [N_UNIT-1:0] v,
                                            input logic [MSB_W-1:0]  p);
    logic [N_UNIT-1:0] r;
    int src;
    for (int i = 0; i < N_UNIT; i++) begin
      src = i - int'(p);
      if (src < 0) src = src + N_UNIT;
      r[i] = v[src];
    end
    return r;
  endfunction

  assign rotated = spin(therm, start_i);
  assign sel_o   = rotate_i ? rotated : therm;

endmodule

// File: rtl/dwa_phase_seq.sv
module dwa_phase_seq
  import dwa_pkg::*;
#(
  parameter int PH1_CYC = 2,
  parameter int PH2_CYC = 2,
  parameter int GAP_CYC = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic ready_o,
  output logic ph1_o,
  output logic ph2_o
);

  localparam int MAX_LEN = (PH1_CYC > PH2_CYC) ?
                           ((PH1_CYC > GAP_CYC) ? PH1_CYC : GAP_CYC) :
                           ((PH2_CYC > GAP_CYC) ? PH2_CYC : GAP_CYC);
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  seq_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_cyc;

  assign last_cyc = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= SEQ_WAIT;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        SEQ_WAIT: if (start_i) begin
          st_q  <= SEQ_PH1;
          cnt_q <= CNT_W'(PH1_CYC - 1);
        end
        SEQ_PH1: if (last_cyc) begin
          st_q  <= SEQ_GAP1;
          cnt_q <= CNT_W'(GAP_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        SEQ_GAP1: if (last_cyc) begin
          st_q  <= SEQ_PH2;
          cnt_q <= CNT_W'(PH2_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        SEQ_PH2: if (last_cyc) begin
          st_q  <= SEQ_GAP2;
          cnt_q <= CNT_W'(GAP_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        SEQ_GAP2: if (last_cyc) begin
          st_q  <= SEQ_WAIT;
          cnt_q <= '0;
        end else cnt_q <= cnt_q - 1'b1;
        default: begin
          st_q  <= SEQ_WAIT;
          cnt_q <= '0;
        end
      endcase
    end
  end

  assign ready_o = (st_q == SEQ_WAIT);
  assign ph1_o   = (st_q == SEQ_PH1);
  assign ph2_o   = (st_q == SEQ_PH2);

  // R6: the two steps are never on together
  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (rst)
    !(ph1_o && ph2_o));

  // R6: at least one quiet cycle before step 2 starts
  assert_gap_before_ph2_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ph2_o) |-> !$past(ph1_o));

  // R6: an accepted start opens step 1 on the next cycle
  assert_start_ph1_R6: assert property (@(posedge clk) disable iff (rst)
    (start_i && ready_o) |=> ph1_o);

  // R10: reset quiets both steps
  assert_seq_reset_R10: assert property (@(posedge clk)
    rst |=> (!ph1_o && !ph2_o && ready_o));

endmodule

// File: rtl/dwa_dac_ctrl.sv
module dwa_dac_ctrl
  import dwa_pkg::*;
#(
  parameter int LSB_W   = DWA_LSB_W,
  parameter int MSB_W   = DWA_MSB_W,
  parameter int PH1_CYC = 2,
  parameter int PH2_CYC = 2,
  parameter int GAP_CYC = 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          idle_i,
  input  logic                          dem_en_i,
  input  logic                          rst_en_i,
  input  logic                          code_valid_i,
  input  logic [LSB_W+MSB_W-1:0]        code_i,
  output logic [LSB_W-1:0]              lsb_sw_o,
  output logic [(1 << MSB_W)-2:0]       unit_sel_o,
  output logic                          ph1_o,
  output logic                          ph2_o,
  output logic                          fb_rst_o
);

  localparam int CODE_W = LSB_W + MSB_W;
  localparam int N_UNIT = (1 << MSB_W) - 1;

  logic              seq_ready;
  logic              capture;
  logic              ptr_adv;
  logic [MSB_W-1:0]  code_msb;
  logic [LSB_W-1:0]  code_lsb;
  logic [MSB_W-1:0]  ptr;
  logic [N_UNIT-1:0] sel_nxt;

  logic [LSB_W-1:0]  lsb_q;
  logic [N_UNIT-1:0] sel_q;
  logic [MSB_W-1:0]  msb_q;
  logic              clr_q;

  assign code_msb = code_i[CODE_W-1:LSB_W];
  assign code_lsb = code_i[LSB_W-1:0];
  assign capture  = code_valid_i && seq_ready && !idle_i;
  assign ptr_adv  = capture && dem_en_i;

  dwa_pointer #(.MSB_W(MSB_W)) u_ptr (
    .clk    (clk),
    .rst    (rst),
    .adv_i  (ptr_adv),
    .step_i (code_msb),
    .ptr_o  (ptr)
  );

  dwa_unit_select #(.MSB_W(MSB_W)) u_sel (
    .count_i  (code_msb),
    .start_i  (ptr),
    .rotate_i (dem_en_i),
    .sel_o    (sel_nxt)
  );

  dwa_phase_seq #(
    .PH1_CYC (PH1_CYC),
    .PH2_CYC (PH2_CYC),
    .GAP_CYC (GAP_CYC)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start_i (capture),
    .ready_o (seq_ready),
    .ph1_o   (ph1_o),
    .ph2_o   (ph2_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lsb_q <= '0;
      sel_q <= '0;
      msb_q <= '0;
      clr_q <= 1'b0;
    end else if (capture) begin
      lsb_q <= code_lsb;
      sel_q <= sel_nxt;
      msb_q <= code_msb;
      clr_q <= rst_en_i;
    end
  end

  assign lsb_sw_o   = lsb_q;
  assign unit_sel_o = sel_q;
  assign fb_rst_o   = ph1_o && clr_q;

  // R2: stored selection carries as many cells as the stored count
  assert_sel_count_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(sel_q) == int'(msb_q));

  // R4: a rotated run begins at the index held before acceptance
  assert_run_start_R4: assert property (@(posedge clk) disable iff (rst)
    (capture && dem_en_i && code_msb != '0) |=> sel_q[$past(ptr)]);

  // R3: a fixed run begins at cell 0
  assert_fixed_start_R3: assert property (@(posedge clk) disable iff (rst)
    (capture && !dem_en_i && code_msb != '0) |=> sel_q[0]);

  // R3: fixed mode leaves the index alone
  assert_fixed_ptr_R3: assert property (@(posedge clk) disable iff (rst)
    (capture && !dem_en_i) |=> $stable(ptr));

  // R7: the clear only appears inside step 1
  assert_clr_in_ph1_R7: assert property (@(posedge clk) disable iff (rst)
    fb_rst_o |-> ph1_o);

  // R8: strobes while busy leave the outputs alone
  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (rst)
    (code_valid_i && !seq_ready) |=> ($stable(sel_q) && $stable(lsb_q) && $stable(ptr)));

  // R9: idle freezes selection and switching
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (idle_i && seq_ready) |=> ($stable(sel_q) && !ph1_o && !ph2_o));

  // R10: reset clears the data outputs
  assert_out_reset_R10: assert property (@(posedge clk)
    rst |=> (sel_q == '0 && lsb_q == '0 && !fb_rst_o));

endmodule

// File: tb/tb_dwa_dac_ctrl.sv
module tb_dwa_dac_ctrl;

  localparam int NU = 63;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        idle_i = 1'b0;
  logic        dem_en_i = 1'b0;
  logic        rst_en_i = 1'b0;
  logic        code_valid_i = 1'b0;
  logic [11:0] code_i = '0;
  logic [5:0]  lsb_sw_o;
  logic [62:0] unit_sel_o;
  logic        ph1_o, ph2_o, fb_rst_o;

  int checks = 0;
  int fails  = 0;
  int mptr   = 0;
  int use_cnt [NU];
  logic [62:0] last_sel = '0;

  always #4 clk = ~clk;

  dwa_dac_ctrl dut (
    .clk(clk), .rst(rst), .idle_i(idle_i), .dem_en_i(dem_en_i),
    .rst_en_i(rst_en_i), .code_valid_i(code_valid_i), .code_i(code_i),
    .lsb_sw_o(lsb_sw_o), .unit_sel_o(unit_sel_o), .ph1_o(ph1_o),
    .ph2_o(ph2_o), .fb_rst_o(fb_rst_o)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected cells: walk m steps from start, wrapping at 63
  function automatic logic [62:0] model_sel(input int m, input int start);
    logic [62:0] v = '0;
    for (int k = 0; k < m; k++) v[(start + k) % NU] = 1'b1;
    return v;
  endfunction

  task automatic conv(input int m, input int l, input bit dem, input bit clr,
                      input bit tally, input bit poke);
    logic [62:0] es;
    es = model_sel(m, dem ? mptr : 0);
    @(negedge clk);
    code_i = 12'((m << 6) | l);
    dem_en_i = dem; rst_en_i = clr; code_valid_i = 1'b1;
    @(negedge clk);
    code_valid_i = 1'b0;
    if (dem) mptr = (mptr + m) % NU;
    for (int c = 0; c < 6; c++) begin
      bit e1, e2;
      e1 = (c < 2);
      e2 = (c == 3 || c == 4);
      chk(ph1_o === e1, "R6 ph1", 64'(ph1_o), 64'(e1));
      chk(ph2_o === e2, "R6 ph2", 64'(ph2_o), 64'(e2));
      chk(fb_rst_o === (e1 && clr), "R7 fb clear", 64'(fb_rst_o), 64'(e1 && clr));
      chk(unit_sel_o === es, dem ? "R4 rotated selection" : "R3 fixed selection",
          64'(unit_sel_o), 64'(es));
      chk(lsb_sw_o === 6'(l), "R1 binary part", 64'(lsb_sw_o), 64'(l));
      if (c == 0) begin
        chk($countones(unit_sel_o) == m, "R2 cell count",
            64'($countones(unit_sel_o)), 64'(m));
        if (tally) for (int i = 0; i < NU; i++) use_cnt[i] += int'(unit_sel_o[i]);
      end
      if (poke && c == 1) begin
        code_i = 12'hFFF; code_valid_i = 1'b1;   // R8 strobe while busy
      end else if (poke && c == 2) begin
        code_valid_i = 1'b0;
      end
      @(negedge clk);
    end
    last_sel = es;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int mn, mx;
    void'($urandom(32'd1234));
    for (int i = 0; i < NU; i++) use_cnt[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(unit_sel_o === '0, "R10 sel", 64'(unit_sel_o), 64'd0);
    chk(lsb_sw_o === '0, "R10 lsb", 64'(lsb_sw_o), 64'd0);
    chk(!ph1_o && !ph2_o && !fb_rst_o, "R10 switches",
        64'({ph1_o, ph2_o, fb_rst_o}), 64'd0);

    // directed rotation corners (R4, R2)
    conv(1, 5, 1, 1, 1, 0);   // start index 0 after reset
    conv(0, 9, 1, 0, 1, 0);   // empty, index stays
    conv(63, 0, 1, 1, 1, 0);  // all cells
    conv(61, 63, 1, 0, 1, 0); // lands at index 62
    conv(4, 1, 1, 1, 1, 0);   // wraps past 62
    // R3 fixed mode, index must be kept for the next rotated code
    conv(7, 2, 0, 0, 0, 0);
    conv(3, 3, 1, 0, 1, 0);
    // R8 strobe during a busy conversion
    conv(10, 17, 1, 1, 1, 1);
    conv(2, 4, 1, 0, 1, 0);
    // R9 idle blocks acceptance
    @(negedge clk);
    idle_i = 1'b1; code_i = 12'h2A5; code_valid_i = 1'b1; dem_en_i = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk(!ph1_o && !ph2_o, "R9 no switching", 64'({ph1_o, ph2_o}), 64'd0);
      chk(unit_sel_o === last_sel, "R9 sel held", 64'(unit_sel_o), 64'(last_sel));
    end
    code_valid_i = 1'b0; idle_i = 1'b0;
    conv(5, 8, 1, 0, 1, 0);

    // random codes, occasional fixed-mode ones not tallied
    for (int n = 0; n < 400; n++) begin
      bit d;
      d = ($urandom % 8) != 0;
      conv(int'($urandom % 64), int'($urandom % 64), d, bit'($urandom % 2), d, 0);
    end

    // R5 usage balance
    mn = use_cnt[0]; mx = use_cnt[0];
    for (int i = 1; i < NU; i++) begin
      if (use_cnt[i] < mn) mn = use_cnt[i];
      if (use_cnt[i] > mx) mx = use_cnt[i];
    end
    chk(mx - mn <= 1, "R5 usage spread", 64'(mx - mn), 64'd1);

    // R10 reset in mid-run restores index 0
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(unit_sel_o === '0 && !ph1_o, "R10 mid reset", 64'(unit_sel_o), 64'd0);
    mptr = 0;
    conv(2, 0, 1, 0, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule